// File: doc/BRIEF.md
# Ethernet Destination Address Filter

This block decides whether an incoming Ethernet frame is kept, based only on its six-byte destination address. The receive path hands the address over one byte per clock as it arrives, marking the first byte with a start flag. The block gathers the bytes and runs a CRC-32 over them at the same time. One clock after the sixth byte it raises a one-cycle `dec_valid` pulse, with `dec_accept` giving the verdict.

The verdict draws on several inputs:
- a 48-bit station address, split over a 32-bit word and a 16-bit word;
- a 64-bit multicast hash table, split over two 32-bit words;
- a broadcast-reject control;
- a promiscuous control.

Multicast frames are looked up in the hash table. Six bits of the address CRC give the table position. Frame CRC checking and length checks belong elsewhere in the receive path.

Top module: `rxaddr_filter`

## Requirements
- R1: After reset, `dec_valid` and `dec_accept` are both 0 until a full address has been received.
- R2: `dec_valid` is high for exactly one cycle, the cycle after the clock edge that captures the sixth address byte, and `dec_accept` is 0 whenever `dec_valid` is 0.
- R3: The station address is, in wire order: byte0 = `stn_hi[15:8]`, byte1 = `stn_hi[7:0]`, byte2 = `stn_lo[31:24]`, byte3 = `stn_lo[23:16]`, byte4 = `stn_lo[15:8]`, byte5 = `stn_lo[7:0]`. A destination equal to it is accepted.
- R4: With promiscuous mode off, a destination whose byte0 bit0 is 0 and which differs from the station address in any byte is rejected.
- R5: A destination with byte0 bit0 = 1 that is not all-ones is a multicast address. With promiscuous mode off, it is accepted exactly when the selected hash table bit is 1. The table position is bits 31:26 of a CRC register run as follows:
  - preset to all ones;
  - fed with the six bytes in wire order, each byte LSB first;
  - updated per bit with the reflected polynomial 0xEDB88320;
  - no final complement.
- R6: Bit 5 of the table position picks the table word: 0 selects `tbl_lo`, 1 selects `tbl_hi`. Bits 4:0 pick the bit inside that word.
- R7: An all-ones destination is accepted when `cfg_bcast_reject` is 0 and rejected when it is 1, whatever the hash table holds (promiscuous off).
- R8: With `cfg_promisc` = 1, every completed address is accepted, including broadcasts while `cfg_bcast_reject` = 1.
- R9: `in_first` with `in_valid` always starts a new address, abandoning any partial one. Bytes with `in_valid` but without `in_first` that arrive after the sixth byte, or before any start, are ignored and produce no decision.
- R10: Cycles with `in_valid` = 0 between address bytes pause collection without changing the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | An address byte is present on `in_data` |
| in_first | input | 1 | This byte is byte0 of a new address (valid with `in_valid`) |
| in_data | input | 8 | Address byte |
| stn_lo | input | 32 | Station address bytes 2..5 (byte2 in the top bits) |
| stn_hi | input | 16 | Station address bytes 0..1 (byte0 in the top bits) |
| tbl_lo | input | 32 | Hash table bins 0..31 |
| tbl_hi | input | 32 | Hash table bins 32..63 |
| cfg_bcast_reject | input | 1 | Reject all-ones destinations |
| cfg_promisc | input | 1 | Accept every destination |
| dec_valid | output | 1 | One-cycle decision strobe |
| dec_accept | output | 1 | Frame accepted (meaningful with `dec_valid`) |

## Verification
The exact station address, single-byte mismatches and a byte-order swap of the same address separate correct register ordering from near misses. Multicast addresses are searched out in the bench so that their hash position falls in each table word. Each is tried three ways: with only its own bit set, with an empty table, and with the same bit set in the other word. This tells correct CRC indexing apart from a wrong word or bit choice. Broadcast is tried under both reject settings with full and empty tables, and promiscuous mode is tried against every otherwise-rejected case. Byte gaps, restarts in mid-address and surplus bytes after the sixth confirm that only complete addresses yield exactly one decision.

// File: rtl/rxaf_pkg.sv
package rxaf_pkg;
  localparam int          CRC_W       = 32;
  localparam int          IDX_W       = 6;
  localparam int          WORD_W      = 32;
  localparam logic [31:0] CRC_POLY_RF = 32'hEDB88320;
  localparam logic [31:0] CRC_PRESET  = 32'hFFFFFFFF;

  typedef enum logic [1:0] {
    CLS_UNICAST   = 2'd0,
    CLS_MULTICAST = 2'd1,
    CLS_BROADCAST = 2'd2
  } addr_class_e;

  // Advance the reflected CRC by one byte, least significant bit first.
  function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c,
                                                input logic [7:0] d);
    logic [CRC_W-1:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ d[i]) r = (r >> 1) ^ CRC_POLY_RF;
      else             r = r >> 1;
    end
    return r;
  endfunction

  // Pick one bin of the split 64-bin table using the CRC's top bits.
  function automatic logic hash_lookup(input logic [CRC_W-1:0] c,
                                       input logic [WORD_W-1:0] lo,
                                       input logic [WORD_W-1:0] hi);
    logic [IDX_W-1:0] idx;
    idx = c[CRC_W-1 -: IDX_W];
    return idx[IDX_W-1] ? hi[idx[IDX_W-2:0]] : lo[idx[IDX_W-2:0]];
  endfunction
endpackage

// File: rtl/rxaf_collect.sv
module rxaf_collect #(
  parameter int NBYTES = 6,
  localparam int ADDR_W = 8 * NBYTES,
  localparam int CNT_W  = $clog2(NBYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_first,
  input  logic [7:0]        in_data,
  output logic              byte_take,
  output logic              last_byte,
  output logic [ADDR_W-1:0] dst
);
  logic [CNT_W-1:0] cnt;

  assign byte_take = in_valid &&
                     (in_first || (cnt != '0 && cnt < CNT_W'(NBYTES)));
  assign last_byte = in_valid && !in_first && (cnt == CNT_W'(NBYTES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      dst <= '0;
    end else if (byte_take) begin
      dst <= {dst[ADDR_W-9:0], in_data};
      cnt <= in_first ? CNT_W'(1) : cnt + CNT_W'(1);
    end
  end
endmodule

// File: rtl/rxaf_crc.sv
module rxaf_crc
  import rxaf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             byte_take,
  input  logic             in_first,
  input  logic [7:0]       in_data,
  output logic [CRC_W-1:0] crc
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc <= CRC_PRESET;
    else if (byte_take) crc <= crc_step(in_first ? CRC_PRESET : crc, in_data);
  end
endmodule

// File: rtl/rxaf_decide.sv
module rxaf_decide
  import rxaf_pkg::*;
#(
  parameter int NBYTES = 6,
  localparam int ADDR_W = 8 * NBYTES
) (
  input  logic [ADDR_W-1:0]    dst,
  input  logic [CRC_W-1:0]     crc,
  input  logic [WORD_W-1:0]    stn_lo,
  input  logic [ADDR_W-33:0]   stn_hi,
  input  logic [WORD_W-1:0]    tbl_lo,
  input  logic [WORD_W-1:0]    tbl_hi,
  input  logic                 cfg_bcast_reject,
  input  logic                 cfg_promisc,
  output addr_class_e          cls,
  output logic                 verdict
);
  logic station_hit;
  logic hash_hit;

  assign station_hit = (dst == {stn_hi, stn_lo});
  assign hash_hit    = hash_lookup(crc, tbl_lo, tbl_hi);

  always_comb begin
    if (&dst)                 cls = CLS_BROADCAST;
    else if (dst[ADDR_W-8])   cls = CLS_MULTICAST;
    else                      cls = CLS_UNICAST;
  end

  always_comb begin
    if (cfg_promisc) verdict = 1'b1;
    else begin
      unique case (cls)
        CLS_BROADCAST: verdict = !cfg_bcast_reject;
        CLS_MULTICAST: verdict = station_hit || hash_hit;
        default:       verdict = station_hit;
      endcase
    end
  end
endmodule

// File: rtl/rxaddr_filter.sv
module rxaddr_filter
  import rxaf_pkg::*;
#(
  parameter int NBYTES = 6,
  localparam int ADDR_W = 8 * NBYTES
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic               in_first,
  input  logic [7:0]         in_data,
  input  logic [31:0]        stn_lo,
  input  logic [ADDR_W-33:0] stn_hi,
  input  logic [31:0]        tbl_lo,
  input  logic [31:0]        tbl_hi,
  input  logic               cfg_bcast_reject,
  input  logic               cfg_promisc,
  output logic               dec_valid,
  output logic               dec_accept
);
  logic              byte_take;
  logic              last_byte;
  logic [ADDR_W-1:0] dst;
  logic [CRC_W-1:0]  crc;
  addr_class_e       cls;
  logic              verdict;

  rxaf_collect #(.NBYTES(NBYTES)) u_collect (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_first(in_first),
    .in_data(in_data), .byte_take(byte_take), .last_byte(last_byte), .dst(dst)
  );

  rxaf_crc u_crc (
    .clk(clk), .rst_n(rst_n), .byte_take(byte_take), .in_first(in_first),
    .in_data(in_data), .crc(crc)
  );

  rxaf_decide #(.NBYTES(NBYTES)) u_decide (
    .dst(dst), .crc(crc), .stn_lo(stn_lo), .stn_hi(stn_hi),
    .tbl_lo(tbl_lo), .tbl_hi(tbl_hi), .cfg_bcast_reject(cfg_bcast_reject),
    .cfg_promisc(cfg_promisc), .cls(cls), .verdict(verdict)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dec_valid <= 1'b0;
    else        dec_valid <= last_byte;
  end

  assign dec_accept = dec_valid && verdict;
endmodule

// File: rtl/rxaf_checker.sv
module rxaf_checker #(
  parameter int ADDR_W = 48
) (
  input logic              clk,
  input logic              rst_n,
  input logic              dec_valid,
  input logic              dec_accept,
  input logic              last_byte,
  input logic              cfg_promisc,
  input logic              cfg_bcast_reject,
  input logic [ADDR_W-1:0] dst
);
  // R2: decision follows the sixth byte by one cycle
  a_r2_valid_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    last_byte |=> dec_valid);
  // R2: single-cycle strobe
  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |=> !dec_valid);
  // R2: no verdict without strobe
  a_r2_accept_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid |-> !dec_accept);
  // R8: promiscuous accepts everything
  a_r8_promisc_accepts: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && cfg_promisc) |-> dec_accept);
  // R7: broadcast blocked when rejection is on
  a_r7_bcast_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && !cfg_promisc && cfg_bcast_reject && (&dst)) |-> !dec_accept);
endmodule

bind rxaddr_filter rxaf_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_accept(dec_accept),
  .last_byte(last_byte), .cfg_promisc(cfg_promisc),
  .cfg_bcast_reject(cfg_bcast_reject), .dst(dst)
);

// File: tb/rxaddr_filter_tb.sv
module rxaddr_filter_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_first = 1'b0;
  logic [7:0]  in_data = '0;
  logic [31:0] stn_lo = 32'h2C3D4E5F;
  logic [15:0] stn_hi = 16'h0A1B;
  logic [31:0] tbl_lo = '0, tbl_hi = '0;
  logic        cfg_bcast_reject = 1'b0, cfg_promisc = 1'b0;
  logic        dec_valid, dec_accept;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  localparam logic [47:0] STATION = 48'h0A1B2C3D4E5F;
  localparam logic [47:0] BCAST   = 48'hFFFFFFFFFFFF;

  always #10 clk = ~clk;

  rxaddr_filter u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_first(in_first),
    .in_data(in_data), .stn_lo(stn_lo), .stn_hi(stn_hi), .tbl_lo(tbl_lo),
    .tbl_hi(tbl_hi), .cfg_bcast_reject(cfg_bcast_reject),
    .cfg_promisc(cfg_promisc), .dec_valid(dec_valid), .dec_accept(dec_accept)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  // Bytewise reflected CRC: fold a whole byte in, then eight shifts.
  function automatic logic [5:0] ref_index(input logic [47:0] a);
    logic [31:0] c = 32'hFFFFFFFF;
    for (int k = 0; k < 6; k++) begin
      c = c ^ {24'h0, a[47 - 8*k -: 8]};
      for (int j = 0; j < 8; j++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    end
    return c[31:26];
  endfunction

  function automatic logic [47:0] find_mcast(input logic want_hi);
    logic [47:0] a;
    for (int n = 0; n < 256; n++) begin
      a = 48'h01005E000000 + 48'(n);
      if (ref_index(a)[5] == want_hi) return a;
    end
    return 48'h01005E000000;
  endfunction

  // Send one address; optional idle cycle after each byte. Returns the
  // decision seen one cycle after the sixth byte; checks for stray strobes.
  task automatic send(input logic [47:0] a, input bit gaps,
                      output logic v, output logic acc);
    bit stray = 1'b0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (dec_valid) stray = 1'b1;
      in_valid = 1'b1; in_first = (k == 0); in_data = a[47 - 8*k -: 8];
      if (gaps && k < 5) begin
        @(negedge clk);
        if (dec_valid) stray = 1'b1;
        in_valid = 1'b0; in_first = 1'b0;
      end
    end
    @(negedge clk);
    in_valid = 1'b0; in_first = 1'b0;
    v = dec_valid; acc = dec_accept;
    @(negedge clk);
    check("R2 strobe one cycle wide", {31'h0, dec_valid}, 32'h0);
    check("R2 no strobe before sixth byte", {31'h0, stray}, 32'h0);
  endtask

  task automatic expect_decision(input string req, input logic [47:0] a,
                                 input bit gaps, input logic exp_acc);
    logic v, acc;
    send(a, gaps, v, acc);
    check({req, " valid"}, {31'h0, v}, 32'h1);
    check({req, " accept"}, {31'h0, acc}, {31'h0, exp_acc});
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 valid after reset", {31'h0, dec_valid}, 32'h0);
    check("R1 accept after reset", {31'h0, dec_accept}, 32'h0);
  endtask

  task automatic t_unicast();
    expect_decision("R3 station match", STATION, 1'b0, 1'b1);
    expect_decision("R4 last byte differs", 48'h0A1B2C3D4E5E, 1'b0, 1'b0);
    expect_decision("R4 first byte differs", 48'h0C1B2C3D4E5F, 1'b0, 1'b0);
    expect_decision("R3 swapped word order", 48'h2C3D4E5F0A1B, 1'b0, 1'b0);
  endtask

  task automatic t_multicast();
    for (int w = 0; w < 2; w++) begin
      logic [47:0] a = find_mcast(w[0]);
      logic [5:0]  ix = ref_index(a);
      logic [31:0] bitv = 32'h1 << ix[4:0];
      tbl_lo = w[0] ? 32'h0 : bitv; tbl_hi = w[0] ? bitv : 32'h0;
      expect_decision("R5 hash bit set", a, 1'b0, 1'b1);
      tbl_lo = '0; tbl_hi = '0;
      expect_decision("R5 hash table empty", a, 1'b0, 1'b0);
      tbl_lo = w[0] ? bitv : 32'h0; tbl_hi = w[0] ? 32'h0 : bitv;
      expect_decision("R6 bit in other word", a, 1'b0, 1'b0);
      tbl_lo = w[0] ? 32'hFFFFFFFF : ~bitv; tbl_hi = w[0] ? ~bitv : 32'hFFFFFFFF;
      expect_decision("R6 all bins but selected", a, 1'b0, 1'b0);
      tbl_lo = '0; tbl_hi = '0;
    end
  endtask

  task automatic t_broadcast();
    cfg_bcast_reject = 1'b0;
    expect_decision("R7 broadcast allowed", BCAST, 1'b0, 1'b1);
    cfg_bcast_reject = 1'b1; tbl_lo = '1; tbl_hi = '1;
    expect_decision("R7 broadcast rejected full table", BCAST, 1'b0, 1'b0);
    tbl_lo = '0; tbl_hi = '0;
    expect_decision("R7 broadcast rejected", BCAST, 1'b0, 1'b0);
    cfg_bcast_reject = 1'b0;
  endtask

  task automatic t_promisc();
    cfg_promisc = 1'b1; cfg_bcast_reject = 1'b1;
    expect_decision("R8 unicast miss", 48'h001122334455, 1'b0, 1'b1);
    expect_decision("R8 broadcast", BCAST, 1'b0, 1'b1);
    expect_decision("R8 multicast empty table", 48'h01005E000001, 1'b0, 1'b1);
    cfg_promisc = 1'b0; cfg_bcast_reject = 1'b0;
  endtask

  task automatic t_gaps();
    expect_decision("R10 gapped station", STATION, 1'b1, 1'b1);
    expect_decision("R10 gapped miss", 48'h0A1B2C3D4E00, 1'b1, 1'b0);
  endtask

  task automatic t_restart_extra();
    bit seen = 1'b0;
    // Stray bytes before any start and after a complete address.
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      if (dec_valid) seen = 1'b1;
      in_valid = 1'b1; in_first = 1'b0; in_data = 8'h5A;
    end
    @(negedge clk); in_valid = 1'b0;
    repeat (2) begin @(negedge clk); if (dec_valid) seen = 1'b1; end
    check("R9 no decision from unstarted bytes", {31'h0, seen}, 32'h0);
    expect_decision("R9 address before extras", STATION, 1'b0, 1'b1);
    seen = 1'b0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (dec_valid) seen = 1'b1;
      in_valid = 1'b1; in_first = 1'b0; in_data = 8'hFF;
    end
    @(negedge clk); in_valid = 1'b0;
    repeat (2) begin @(negedge clk); if (dec_valid) seen = 1'b1; end
    check("R9 surplus bytes ignored", {31'h0, seen}, 32'h0);
    // Partial address abandoned by a new start.
    seen = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      in_valid = 1'b1; in_first = (k == 0); in_data = 8'hFF;
    end
    expect_decision("R9 restart mid-address", STATION, 1'b0, 1'b1);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_unicast();
    t_multicast();
    t_broadcast();
    t_promisc();
    t_gaps();
    t_restart_extra();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule